// File: doc/BRIEF.md
# Display Byte Palette Translator

This block turns one display byte, fetched elsewhere from video memory, into a run of 8-bit colour values, one per pixel. It presents them on consecutive clock cycles, with the most significant pixel first. The pixel layout comes from a two-bit colour-depth field. In the two-, four- and sixteen-colour depths the bits of the byte form palette indices. The four- and sixteen-colour depths use an interleaved bit order. In the direct depth the byte itself is the colour.

Indices 0 to 7 select one of eight palette bytes supplied with the current display band. Indices 8 to 15 are built from a five-bit bias value and the low three index bits. In two-colour depth, two enable inputs move the palette window up according to marked bits. For graphics sources the marked bits come from the display byte itself, and those bits are blanked. For character sources they come from the character code. For attribute sources, a companion byte supplies a per-byte background and foreground index.

A pulse on `inLoad` samples every input. A new load cuts short any run still in progress.

Top module: `pix_colour_xlat`

## Requirements
- R1: After reset, and at any time no pixel is being presented, `pixValid` is 0 and `pixColour` is 8'h00.
- R2: A load drives `pixValid` high from the cycle after the load edge for exactly N cycles. N is 8 for `colourMode` 2'b00, 4 for 2'b01, 2 for 2'b10 and 1 for 2'b11. N is always 8 when `srcKind` is 2'b10 (attribute). All inputs are sampled at the load edge.
- R3: With `colourMode` 2'b11 and a non-attribute source, the single pixel equals the loaded byte.
- R4: In two-colour depth, pixel p (p = 0 first) takes its index from bit 7-p of the byte.
- R5: In four-colour depth, pixel p takes index {bit 3-p, bit 7-p}, with the first-listed bit as the index MSB.
- R6: In sixteen-colour depth, the first pixel takes index {b1,b5,b3,b7} and the second takes {b0,b4,b2,b6}, MSB first.
- R7: Index i below 8 yields palette byte `palette[8i+7:8i]`. Index i of 8 or more yields {`biasBits`, i[2:0]}.
- R8: For a graphics source (`srcKind` 2'b00 or 2'b11) in two-colour depth with `altHiEn` set, byte bit 7 is treated as 0. If that bit was 1, every index of the byte is raised by 2.
- R9: Under the same conditions with `altLoEn` set, byte bit 0 is treated as 0. If that bit was 1, every index is raised by 4. When both raises apply they add together.
- R10: For a character source (`srcKind` 2'b01) in two-colour depth, `altHiEn` with code bit 7 set raises indices by 2, and `altLoEn` with code bit 6 set raises them by 4. The display byte is not altered.
- R11: For an attribute source, each pixel bit of 1 selects index `inAux[3:0]` (foreground) and each pixel bit of 0 selects `inAux[7:4]` (background).
- R12: In four-, sixteen- and direct depth, `altHiEn` and `altLoEn` have no effect on the output.
- R13: A load while a run is in progress abandons the rest of that run. The new byte's first pixel appears in the cycle after the new load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inLoad | input | 1 | Sample all inputs and start a pixel run |
| inByte | input | 8 | Display byte |
| inAux | input | 8 | Character code or attribute byte |
| colourMode | input | 2 | 00 two, 01 four, 10 sixteen, 11 direct |
| srcKind | input | 2 | 00 graphics, 01 character, 10 attribute, 11 graphics |
| altHiEn | input | 1 | Enable raise-by-2 alternate palette |
| altLoEn | input | 1 | Enable raise-by-4 alternate palette |
| palette | input | 64 | Eight palette bytes, entry i at bits 8i+7:8i |
| biasBits | input | 5 | Upper five bits of palette entries 8 to 15 |
| pixValid | output | 1 | A pixel colour is presented |
| pixColour | output | 8 | Pixel colour byte |

## Verification
The hardest case to reach is a restart in mid-run. The old run's remaining pixels must vanish, while the pixel already on the output in the load cycle still counts. The stimulus issues a second load on the cycle straight after the first byte's load. The expectation queue is cleared at that edge, so any leftover or shifted pixel shows up as a mismatch. A second hard case is the stacked alternate offsets. A byte with both bit 7 and bit 0 set, with both enables on, must reach indices 6 and 7 with the edge bits blanked.

// File: rtl/palxlat_pkg.sv
package palxlat_pkg;

  typedef enum logic [1:0] {
    CM_TWO     = 2'b00,
    CM_FOUR    = 2'b01,
    CM_SIXTEEN = 2'b10,
    CM_DIRECT  = 2'b11
  } colourMode_e;

  typedef enum logic [1:0] {
    SRC_GRAPHIC = 2'b00,
    SRC_CHAR    = 2'b01,
    SRC_ATTR    = 2'b10,
    SRC_SPARE   = 2'b11
  } srcKind_e;

  localparam int POS_W = 3;

  typedef struct packed {
    logic             capture;
    logic             advance;
    logic             active;
    logic [POS_W-1:0] pos;
  } ctrlStrobe_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import palxlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inLoad,
  input  logic [1:0]  colourMode,
  input  logic [1:0]  srcKind,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = POS_W + 1;

  logic [CNT_W-1:0] remain;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] runLen;

  // Number of pixels produced by one byte
  always_comb begin
    if (srcKind == SRC_ATTR) begin
      runLen = CNT_W'(8);
    end else begin
      case (colourMode)
        CM_TWO:     runLen = CNT_W'(8);
        CM_FOUR:    runLen = CNT_W'(4);
        CM_SIXTEEN: runLen = CNT_W'(2);
        default:    runLen = CNT_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      pos    <= '0;
    end else if (inLoad) begin
      remain <= runLen;
      pos    <= '0;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
      pos    <= pos + POS_W'(1);
    end
  end

  always_comb begin
    strobe.capture = inLoad;
    strobe.advance = (remain != '0) && !inLoad;
    strobe.active  = (remain != '0);
    strobe.pos     = pos;
  end

endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import palxlat_pkg::*;
#(
  parameter int COLOUR_W    = 8,
  parameter int PAL_ENTRIES = 8,
  parameter int BIAS_W      = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [7:0]                    inByte,
  input  logic [7:0]                    inAux,
  input  logic [1:0]                    colourMode,
  input  logic [1:0]                    srcKind,
  input  logic                          altHiEn,
  input  logic                          altLoEn,
  input  logic [PAL_ENTRIES*COLOUR_W-1:0] palette,
  input  logic [BIAS_W-1:0]             biasBits,
  output logic [COLOUR_W-1:0]           pixColour
);

  localparam int IDX_W    = 4;
  localparam int SEL_W    = $clog2(PAL_ENTRIES);
  localparam int OFFSET_W = 3;

  // Captured state
  logic [1:0]                    modeQ;
  logic                          attrQ;
  logic [7:0]                    byteQ;
  logic [7:0]                    auxQ;
  logic [OFFSET_W-1:0]           offQ;
  logic [PAL_ENTRIES*COLOUR_W-1:0] palQ;
  logic [BIAS_W-1:0]             biasQ;

  // Load-time remapping
  logic                isGraphic;
  logic                isChar;
  logic                twoDepth;
  logic [7:0]          maskedByte;
  logic [OFFSET_W-1:0] altOff;

  always_comb begin
    isGraphic  = (srcKind == SRC_GRAPHIC) || (srcKind == SRC_SPARE);
    isChar     = (srcKind == SRC_CHAR);
    twoDepth   = (colourMode == CM_TWO);
    maskedByte = inByte;
    altOff     = '0;
    if (twoDepth && isGraphic) begin
      if (altHiEn) begin
        maskedByte[7] = 1'b0;
        if (inByte[7]) altOff = altOff + OFFSET_W'(2);
      end
      if (altLoEn) begin
        maskedByte[0] = 1'b0;
        if (inByte[0]) altOff = altOff + OFFSET_W'(4);
      end
    end else if (twoDepth && isChar) begin
      if (altHiEn && inAux[7]) altOff = altOff + OFFSET_W'(2);
      if (altLoEn && inAux[6]) altOff = altOff + OFFSET_W'(4);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      attrQ <= 1'b0;
      byteQ <= '0;
      auxQ  <= '0;
      offQ  <= '0;
      palQ  <= '0;
      biasQ <= '0;
    end else if (strobe.capture) begin
      modeQ <= colourMode;
      attrQ <= (srcKind == SRC_ATTR);
      byteQ <= maskedByte;
      auxQ  <= inAux;
      offQ  <= altOff;
      palQ  <= palette;
      biasQ <= biasBits;
    end
  end

  // Palette entries unpacked
  logic [COLOUR_W-1:0] palArr [PAL_ENTRIES];

  genvar gi;
  generate
    for (gi = 0; gi < PAL_ENTRIES; gi++) begin : gPal
      assign palArr[gi] = palQ[gi*COLOUR_W +: COLOUR_W];
    end
  endgenerate

  // Pixel index extraction
  logic [IDX_W-1:0]    pixIdx;
  logic                pixBit;
  logic [2:0]          hiSel;
  logic [2:0]          loSel;
  logic [COLOUR_W-1:0] lutColour;
  logic [COLOUR_W-1:0] rawColour;

  always_comb begin
    hiSel  = 3'd7 - strobe.pos;
    loSel  = 3'd3 - strobe.pos;
    pixBit = byteQ[hiSel];
    pixIdx = '0;
    if (attrQ) begin
      pixIdx = pixBit ? auxQ[3:0] : auxQ[7:4];
    end else begin
      case (modeQ)
        CM_TWO:  pixIdx = {3'b000, pixBit} + {1'b0, offQ};
        CM_FOUR: pixIdx = {2'b00, byteQ[loSel], byteQ[hiSel]};
        CM_SIXTEEN: begin
          if (strobe.pos[0] == 1'b0)
            pixIdx = {byteQ[1], byteQ[5], byteQ[3], byteQ[7]};
          else
            pixIdx = {byteQ[0], byteQ[4], byteQ[2], byteQ[6]};
        end
        default: pixIdx = '0;
      endcase
    end
  end

  always_comb begin
    if (pixIdx[IDX_W-1])
      lutColour = {biasQ, pixIdx[COLOUR_W-BIAS_W-1:0]};
    else
      lutColour = palArr[pixIdx[SEL_W-1:0]];
    if (!attrQ && modeQ == CM_DIRECT)
      rawColour = byteQ;
    else
      rawColour = lutColour;
    pixColour = strobe.active ? rawColour : '0;
  end

endmodule

// File: rtl/pix_colour_xlat.sv
module pix_colour_xlat
  import palxlat_pkg::*;
#(
  parameter int COLOUR_W    = 8,
  parameter int PAL_ENTRIES = 8,
  parameter int BIAS_W      = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inLoad,
  input  logic [7:0]                      inByte,
  input  logic [7:0]                      inAux,
  input  logic [1:0]                      colourMode,
  input  logic [1:0]                      srcKind,
  input  logic                            altHiEn,
  input  logic                            altLoEn,
  input  logic [PAL_ENTRIES*COLOUR_W-1:0] palette,
  input  logic [BIAS_W-1:0]               biasBits,
  output logic                            pixValid,
  output logic [COLOUR_W-1:0]             pixColour
);

  ctrlStrobe_t strobe;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inLoad     (inLoad),
    .colourMode (colourMode),
    .srcKind    (srcKind),
    .strobe     (strobe)
  );

  xlat_datapath #(
    .COLOUR_W    (COLOUR_W),
    .PAL_ENTRIES (PAL_ENTRIES),
    .BIAS_W      (BIAS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inByte     (inByte),
    .inAux      (inAux),
    .colourMode (colourMode),
    .srcKind    (srcKind),
    .altHiEn    (altHiEn),
    .altLoEn    (altLoEn),
    .palette    (palette),
    .biasBits   (biasBits),
    .pixColour  (pixColour)
  );

  assign pixValid = strobe.active;

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inLoad,
  input logic [7:0]  inByte,
  input logic [7:0]  inAux,
  input logic [1:0]  colourMode,
  input logic [1:0]  srcKind,
  input logic [4:0]  biasBits,
  input logic        pixValid,
  input logic [7:0]  pixColour
);

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    inLoad |=> pixValid); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> pixColour == 8'h00); // R1

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inLoad && colourMode == 2'b11 && srcKind != 2'b10) |=> pixColour == $past(inByte)); // R3

  AST_DIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (inLoad && colourMode == 2'b11 && srcKind != 2'b10) ##1 !inLoad |=> !pixValid); // R2

  AST_SIXTEEN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (inLoad && colourMode == 2'b10 && srcKind != 2'b10) ##1 !inLoad ##1 !inLoad |=> !pixValid); // R2

  AST_ATTR_BIAS: assert property (@(posedge clk) disable iff (!rstN)
    (inLoad && srcKind == 2'b10 && inByte == 8'hFF && inAux[3])
      |=> pixColour == {$past(biasBits), $past(inAux[2:0])}); // R7

endmodule

bind pix_colour_xlat xlat_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inLoad     (inLoad),
  .inByte     (inByte),
  .inAux      (inAux),
  .colourMode (colourMode),
  .srcKind    (srcKind),
  .biasBits   (biasBits),
  .pixValid   (pixValid),
  .pixColour  (pixColour)
);

// File: tb/sim_pix_colour_xlat.sv
module sim_pix_colour_xlat;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inLoad = 1'b0;
  logic [7:0]  inByte = '0;
  logic [7:0]  inAux = '0;
  logic [1:0]  colourMode = '0;
  logic [1:0]  srcKind = '0;
  logic        altHiEn = 1'b0;
  logic        altLoEn = 1'b0;
  logic [63:0] palette;
  logic [4:0]  biasBits = 5'b10101;
  logic        pixValid;
  logic [7:0]  pixColour;

  int checks = 0;
  int errors = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];

  always #5 clk = ~clk;

  pix_colour_xlat u0 (
    .clk(clk), .rstN(rstN), .inLoad(inLoad), .inByte(inByte), .inAux(inAux),
    .colourMode(colourMode), .srcKind(srcKind), .altHiEn(altHiEn), .altLoEn(altLoEn),
    .palette(palette), .biasBits(biasBits), .pixValid(pixValid), .pixColour(pixColour)
  );

  initial begin
    for (int i = 0; i < 8; i++) palette[i*8 +: 8] = 8'h11 * 8'(i + 1);
  end

  // Reference from the requirement text
  function automatic logic [7:0] refColour(input logic [7:0] b, input logic [7:0] a,
      input logic [1:0] m, input logic [1:0] k, input logic hi, input logic lo, input int p);
    logic [3:0] idx;
    int off;
    logic [7:0] bb;
    bb = b;
    off = 0;
    idx = 0;
    if (k != 2'b10 && m == 2'b11) return b;
    if (k == 2'b10 || m == 2'b00) begin
      if (k == 2'b00 || k == 2'b11) begin
        if (hi) begin if (b[7]) off += 2; bb[7] = 1'b0; end
        if (lo) begin if (b[0]) off += 4; bb[0] = 1'b0; end
      end else if (k == 2'b01) begin
        if (hi && a[7]) off += 2;
        if (lo && a[6]) off += 4;
      end
      if (k == 2'b10) idx = bb[7-p] ? a[3:0] : a[7:4];
      else idx = 4'(int'(bb[7-p]) + off);
    end else if (m == 2'b01) begin
      idx = {2'b00, bb[3-p], bb[7-p]};
    end else begin
      idx = (p == 0) ? {bb[1], bb[5], bb[3], bb[7]} : {bb[0], bb[4], bb[2], bb[6]};
    end
    if (idx >= 8) return {biasBits, idx[2:0]};
    return palette[idx*8 +: 8];
  endfunction

  task automatic loadByte(input logic [7:0] b, input logic [7:0] a, input logic [1:0] m,
      input logic [1:0] k, input logic hi, input logic lo, input string tag);
    int n;
    inByte = b; inAux = a; colourMode = m; srcKind = k; altHiEn = hi; altLoEn = lo;
    inLoad = 1'b1;
    @(posedge clk);
    n = (k == 2'b10) ? 8 : (8 >> m);
    expQ.delete();
    tagQ.delete();
    for (int p = 0; p < n; p++) begin
      expQ.push_back(refColour(b, a, m, k, hi, lo, p));
      tagQ.push_back(tag);
    end
    #1 inLoad = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (pixValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected pixel %h, expected none", pixColour);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (pixColour !== e) begin
            errors++;
            $display("FAIL %s: colour %h, expected %h", t, pixColour, e);
          end
        end
      end else begin
        checks++;
        if (expQ.size() != 0) begin
          errors++;
          $display("FAIL R2: run ended with %0d pixels missing, expected 0", expQ.size());
        end else if (pixColour !== 8'h00) begin
          errors++;
          $display("FAIL R1: idle colour %h, expected 00", pixColour);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (pixValid !== 1'b0 || pixColour !== 8'h00) begin
      errors++;
      $display("FAIL R1: reset valid=%b colour=%h, expected 0 00", pixValid, pixColour);
    end
    rstN = 1'b1;
    @(posedge clk); #1;

    loadByte(8'hA5, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0, "R4"); drain();
    loadByte(8'h9C, 8'h00, 2'b01, 2'b00, 1'b0, 1'b0, "R5"); drain();
    loadByte(8'h6B, 8'h00, 2'b10, 2'b00, 1'b0, 1'b0, "R6"); drain();
    loadByte(8'h3C, 8'h00, 2'b11, 2'b00, 1'b0, 1'b0, "R3"); drain();
    loadByte(8'hC3, 8'h00, 2'b00, 2'b00, 1'b1, 1'b0, "R8"); drain();
    loadByte(8'h43, 8'h00, 2'b00, 2'b00, 1'b1, 1'b0, "R8"); drain();
    loadByte(8'hC3, 8'h00, 2'b00, 2'b11, 1'b0, 1'b1, "R9"); drain();
    loadByte(8'h81, 8'h00, 2'b00, 2'b00, 1'b1, 1'b1, "R9"); drain();
    loadByte(8'hF1, 8'hC0, 2'b00, 2'b01, 1'b1, 1'b1, "R10"); drain();
    loadByte(8'h81, 8'h40, 2'b00, 2'b01, 1'b1, 1'b1, "R10"); drain();
    loadByte(8'h5A, 8'h3C, 2'b00, 2'b10, 1'b0, 1'b0, "R11"); drain();
    loadByte(8'h0F, 8'hE9, 2'b11, 2'b10, 1'b1, 1'b1, "R7"); drain();
    loadByte(8'h81, 8'h00, 2'b01, 2'b00, 1'b1, 1'b1, "R12"); drain();
    loadByte(8'h81, 8'hC0, 2'b10, 2'b01, 1'b1, 1'b1, "R12"); drain();
    loadByte(8'h81, 8'h00, 2'b11, 2'b00, 1'b1, 1'b1, "R12"); drain();
    // R13: reload on the cycle after a load
    loadByte(8'hFF, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0, "R13");
    loadByte(8'h96, 8'h00, 2'b01, 2'b00, 1'b0, 1'b0, "R13"); drain();
    // R13: reload late in a run
    loadByte(8'h55, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0, "R13");
    repeat (4) @(posedge clk);
    #1;
    loadByte(8'hE7, 8'h00, 2'b10, 2'b00, 1'b0, 1'b0, "R13"); drain();

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule